// File: doc/BRIEF.md
# I2C Arbitration Loss Detector

This block sits beside the bit engine of an I2C controller and checks, on every bit the engine owns, whether the shared data line carries the level the engine meant to put there. At each SCL rising-edge strobe of a bit the engine transmits, the sampled SDA level is compared with the intended one. A disagreement in either direction means another device is driving the bus. The block then reports a lost arbitration: a one-cycle loss pulse, a matching release command that lets go of the held lines and returns the engine to idle, and a sticky interrupt flag that stays set until software clears it.

When the loss happens while the local controller is sending an address as a master, the transfer is not dropped. The block goes on sampling the remaining address bits from the bus, although the engine is now idle. After the read/write bit it compares the received 7-bit address with the programmed own address. If the two match, it asks the engine to become a slave: a transmitting slave for a read, a receiving slave for a write. Losses found in the data phase, or while acting as a slave, are reported but never lead to a role change. A control input turns checking off entirely.

Top module: `i2c_arb_detect`

## Requirements
- R1: Checking is enabled after reset. While `arb_dis` is 1, no bit produces `arb_lost` and `arb_flag` does not get set.
- R2: A bit is compared only in a cycle where `scl_rise`=1, `tx_bit`=1 and `phase` is not idle (phase encoding: 0 idle, 1 address, 2 data). A mismatch drives `arb_lost` high for exactly the one following cycle.
- R3: Both mismatch directions count as a loss: intended 1 with sampled 0, and intended 0 with sampled 1. Equal levels never count.
- R4: `release_lines` pulses in the same cycle as every `arb_lost` pulse, and `arb_flag` reads 1 from that cycle on unless it is cleared.
- R5: After a loss in the address phase with `is_master`=1, the block samples the remaining address bits at each `scl_rise`, even with `phase` idle and `tx_bit`=0. It raises no further loss until the eighth bit has been taken.
- R6: The first seven address bits, MSB first, are compared with `own_addr`. On a match after such a loss, one cycle after the eighth `scl_rise` a one-cycle pulse appears on `slave_tx_req` if the eighth bit (read/write) is 1, or on `slave_rx_req` if it is 0. There is no pulse without a match.
- R7: A loss in the data phase, or with `is_master`=0, sets the loss pulse and the flag but never produces a role request.
- R8: `arb_flag` stays set until a `flag_clr` strobe. A clear in the same cycle as a new loss leaves the flag at 0, while `arb_lost` still pulses.
- R9: The synchronous reset (`rst`=1) drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_dis | input | 1 | 1 turns arbitration checking off |
| scl_rise | input | 1 | One-cycle strobe at each SCL rising edge |
| tx_bit | input | 1 | Engine owns SDA for the current bit |
| drv_sda | input | 1 | Level the engine intends on SDA |
| sda_in | input | 1 | Sampled SDA level |
| phase | input | 2 | 0 idle, 1 address, 2 data |
| is_master | input | 1 | 1 when the engine acts as master |
| own_addr | input | ADDR_W | Programmed own slave address |
| flag_clr | input | 1 | Software clear strobe for the flag |
| arb_lost | output | 1 | One-cycle arbitration-lost pulse |
| arb_flag | output | 1 | Sticky arbitration-lost interrupt flag |
| release_lines | output | 1 | One-cycle command to release lines and go idle |
| slave_tx_req | output | 1 | Request to enter slave transmit |
| slave_rx_req | output | 1 | Request to enter slave receive |

## Verification
Two events can land in the same cycle: a fresh loss event that wants to set the flag, and a software clear strobe. The bench raises `flag_clr` together with the `scl_rise` of a mismatching bit. The flag must then read 0 while the loss pulse still appears. A second overlap is a loss on the read/write bit itself, where the detection and the address decision fall on the same strobe. A sweep over all 256 competing address bytes, each run against own addresses that match and that miss, covers this case. In that sweep the bench computes the bus byte by wired-AND and predicts which role request is expected.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/arb_cmp.sv
module arb_cmp (
  input  logic clk,
  input  logic rst,
  input  logic arb_dis,
  input  logic scl_rise,
  input  logic tx_bit,
  input  logic phase_act,
  input  logic hold_off,
  input  logic drv_sda,
  input  logic sda_in,
  output logic lose_evt,
  output logic lost_q,
  output logic rel_q
);
  logic mism;

  // either direction of disagreement is a loss (a high seen while low is driven is a bus fault)
  assign mism     = drv_sda ^ sda_in;
  assign lose_evt = scl_rise & tx_bit & phase_act & ~arb_dis & ~hold_off & mism;

  always_ff @(posedge clk) begin
    if (rst) begin
      lost_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      lost_q <= lose_evt;
      rel_q  <= lose_evt;
    end
  end

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    arb_dis |=> !lost_q);
  a_r2_strobe_only: assert property (@(posedge clk) disable iff (rst)
    !scl_rise |=> !lost_q);
  a_r3_equal_no_loss: assert property (@(posedge clk) disable iff (rst)
    (drv_sda == sda_in) |=> !lost_q);
endmodule

// File: rtl/addr_listen.sv
module addr_listen #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              in_addr,
  input  logic              is_master,
  input  logic              sda_in,
  input  logic              lose_evt,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              listen_q,
  output logic              stx_q,
  output logic              srx_q
);
  localparam int CNT_W = $clog2(ADDR_W + 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;
  logic              lose_addr;
  logic              track;
  logic              counting;

  assign lose_addr = lose_evt & in_addr & is_master;
  assign track     = listen_q | lose_addr;
  assign counting  = in_addr | listen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      listen_q <= 1'b0;
      stx_q    <= 1'b0;
      srx_q    <= 1'b0;
    end else begin
      stx_q <= 1'b0;
      srx_q <= 1'b0;
      if (!counting) begin
        cnt <= '0;
      end else if (scl_rise && cnt <= LAST) begin
        cnt <= cnt + 1'b1;
        if (cnt < LAST) sh <= {sh[ADDR_W-2:0], sda_in};
        if (cnt == LAST) begin
          listen_q <= 1'b0;
          if (track && sh == own_addr) begin
            stx_q <= sda_in;
            srx_q <= ~sda_in;
          end
        end else if (lose_addr) begin
          listen_q <= 1'b1;
        end
      end
    end
  end

  a_r6_one_role: assert property (@(posedge clk) disable iff (rst)
    !(stx_q && srx_q));
  a_r6_role_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (stx_q || srx_q) |-> $past(scl_rise));
  a_r5_listen_from_master_loss: assert property (@(posedge clk) disable iff (rst)
    $rose(listen_q) |-> $past(lose_evt && is_master && in_addr));
endmodule

// File: rtl/arb_flag.sv
module arb_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (clr) flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
  end

  a_r8_set_on_loss: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> flag_q);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag_q);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/i2c_arb_detect.sv
module i2c_arb_detect
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arb_dis,
  input  logic              scl_rise,
  input  logic              tx_bit,
  input  logic              drv_sda,
  input  logic              sda_in,
  input  logic [1:0]        phase,
  input  logic              is_master,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              flag_clr,
  output logic              arb_lost,
  output logic              arb_flag,
  output logic              release_lines,
  output logic              slave_tx_req,
  output logic              slave_rx_req
);
  phase_e ph;
  logic   lose_evt;
  logic   listen;

  assign ph = phase_e'(phase);

  arb_cmp u_cmp (
    .clk      (clk),
    .rst      (rst),
    .arb_dis  (arb_dis),
    .scl_rise (scl_rise),
    .tx_bit   (tx_bit),
    .phase_act(ph != PH_IDLE),
    .hold_off (listen),
    .drv_sda  (drv_sda),
    .sda_in   (sda_in),
    .lose_evt (lose_evt),
    .lost_q   (arb_lost),
    .rel_q    (release_lines)
  );

  addr_listen #(.ADDR_W(ADDR_W)) u_listen (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .in_addr  (ph == PH_ADDR),
    .is_master(is_master),
    .sda_in   (sda_in),
    .lose_evt (lose_evt),
    .own_addr (own_addr),
    .listen_q (listen),
    .stx_q    (slave_tx_req),
    .srx_q    (slave_rx_req)
  );

  arb_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set   (lose_evt),
    .clr   (flag_clr),
    .flag_q(arb_flag)
  );

  a_r4_lost_sets_flag: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (arb_flag || $past(flag_clr)));
  a_r5_no_loss_while_listening: assert property (@(posedge clk) disable iff (rst)
    listen |=> !arb_lost);
endmodule

// File: tb/sim_i2c_arb_detect.sv
`timescale 1ns/1ps
module sim_i2c_arb_detect;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arb_dis = 1'b0;
  logic          scl_rise = 1'b0;
  logic          tx_bit = 1'b0;
  logic          drv_sda = 1'b1;
  logic          sda_in = 1'b1;
  logic [1:0]    phase = 2'd0;
  logic          is_master = 1'b1;
  logic [AW-1:0] own_addr = '0;
  logic          flag_clr = 1'b0;
  logic          arb_lost, arb_flag, release_lines, slave_tx_req, slave_rx_req;

  int vectors = 0;
  int miscmp = 0;
  int n_lost, n_tx, n_rx, pair_bad, lost_at, cur_bit;
  int s_lost, s_flag, s_rel;
  logic done = 1'b0;

  always #2 clk = ~clk;

  i2c_arb_detect #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .arb_dis(arb_dis), .scl_rise(scl_rise),
    .tx_bit(tx_bit), .drv_sda(drv_sda), .sda_in(sda_in), .phase(phase),
    .is_master(is_master), .own_addr(own_addr), .flag_clr(flag_clr),
    .arb_lost(arb_lost), .arb_flag(arb_flag), .release_lines(release_lines),
    .slave_tx_req(slave_tx_req), .slave_rx_req(slave_rx_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_lost = 0; n_tx = 0; n_rx = 0; pair_bad = 0; lost_at = -1;
  endtask

  task automatic tick();
    @(negedge clk);
    if (arb_lost) begin n_lost++; lost_at = cur_bit; end
    if (arb_lost != release_lines) pair_bad++;
    if (slave_tx_req) n_tx++;
    if (slave_rx_req) n_rx++;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0; tick();
  endtask

  // one bit: strobe cycle then a quiet cycle; first sample kept in s_*
  task automatic data_bit(input logic [1:0] ph, input logic m, input logic txb,
                          input logic drv, input logic sda, input logic clr);
    phase = ph; is_master = m; tx_bit = txb; drv_sda = drv; sda_in = sda;
    scl_rise = 1'b1; flag_clr = clr;
    tick();
    s_lost = arb_lost; s_flag = arb_flag; s_rel = release_lines;
    scl_rise = 1'b0; flag_clr = 1'b0;
    tick();
    phase = 2'd0; tx_bit = 1'b0; drv_sda = 1'b1; sda_in = 1'b1;
  endtask

  function automatic logic [7:0] calc_bus(input logic [7:0] ours, input logic [7:0] theirs);
    logic lost;
    logic [7:0] bus;
    lost = 1'b0;
    bus = '0;
    for (int i = 7; i >= 0; i--) begin
      logic ob;
      ob = lost ? 1'b1 : ours[i];
      bus[i] = ob & theirs[i];
      if (!lost && ob && !bus[i]) lost = 1'b1;
    end
    return bus;
  endfunction

  task automatic addr_txn(input logic [7:0] ours, input logic [7:0] theirs, input logic [AW-1:0] own);
    logic lost;
    int k;
    logic [7:0] bus;
    logic match;
    own_addr = own; is_master = 1'b1; clr_mon();
    lost = 1'b0; k = -1; bus = '0;
    for (int i = 7; i >= 0; i--) begin
      logic ob, bb;
      ob = lost ? 1'b1 : ours[i];
      bb = ob & theirs[i];
      phase = lost ? 2'd0 : 2'd1;
      tx_bit = !lost; drv_sda = ob; sda_in = bb; cur_bit = i;
      scl_rise = 1'b1;
      tick();
      scl_rise = 1'b0;
      tick();
      bus[i] = bb;
      if (!lost && ob && !bb) begin lost = 1'b1; k = i; end
    end
    phase = 2'd0; tx_bit = 1'b0; drv_sda = 1'b1; sda_in = 1'b1;
    tick(); tick();
    chk("R2 loss count", n_lost, lost ? 1 : 0);
    chk("R2 loss bit", lost_at, k);
    chk("R4 release paired", pair_bad, 0);
    chk("R4 flag after loss", arb_flag, lost ? 1 : 0);
    match = lost && (bus[7:1] == own);
    chk("R5 R6 slave tx request", n_tx, (match && bus[0]) ? 1 : 0);
    chk("R5 R6 slave rx request", n_rx, (match && !bus[0]) ? 1 : 0);
    clear_flag();
    chk("R8 flag cleared", arb_flag, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    clr_mon(); cur_bit = -1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick();
    // R9 reset state
    chk("R9 arb_lost reset", arb_lost, 0);
    chk("R9 arb_flag reset", arb_flag, 0);
    chk("R9 release reset", release_lines, 0);
    chk("R9 slave_tx reset", slave_tx_req, 0);
    chk("R9 slave_rx reset", slave_rx_req, 0);

    // R1 checking active right after reset
    clr_mon();
    data_bit(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1 active after reset", s_lost, 1);
    clear_flag();

    // R3 both directions, equal levels never
    for (int d = 0; d < 4; d++) begin
      logic dv, sv;
      dv = d[1]; sv = d[0];
      clr_mon();
      data_bit(2'd2, 1'b1, 1'b1, dv, sv, 1'b0);
      chk("R3 mismatch direction", s_lost, (dv != sv) ? 1 : 0);
      chk("R4 release with loss", s_rel, (dv != sv) ? 1 : 0);
      chk("R4 flag with loss", s_flag, (dv != sv) ? 1 : 0);
      clear_flag();
    end

    // R1 disable sweep
    arb_dis = 1'b1;
    for (int c = 0; c < 16; c++) begin
      clr_mon();
      data_bit(c[3] ? 2'd2 : 2'd1, c[2], 1'b1, c[1], c[0], 1'b0);
      tick();
      chk("R1 disabled no pulse", n_lost, 0);
      chk("R1 disabled no flag", arb_flag, 0);
    end
    arb_dis = 1'b0;

    // R2 gating: tx_bit low, idle phase, no strobe
    clr_mon();
    data_bit(2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 tx_bit low ignored", n_lost + arb_flag, 0);
    clr_mon();
    data_bit(2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 idle phase ignored", n_lost + arb_flag, 0);
    clr_mon();
    phase = 2'd2; tx_bit = 1'b1; drv_sda = 1'b1; sda_in = 1'b0;
    repeat (6) tick();
    phase = 2'd0; tx_bit = 1'b0; sda_in = 1'b1;
    tick();
    chk("R2 no strobe ignored", n_lost + arb_flag, 0);

    // R7 data-phase loss then a bus byte that matches own address: no role change
    own_addr = 7'h5A;
    clr_mon();
    data_bit(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] pat;
      pat = {7'h5A, 1'b1};
      sda_in = pat[i]; scl_rise = 1'b1; tick(); scl_rise = 1'b0; tick();
    end
    tick();
    chk("R7 data loss pulse", n_lost, 1);
    chk("R7 data loss flag", arb_flag, 1);
    chk("R7 data loss no role", n_tx + n_rx, 0);
    clear_flag();

    // R7 slave-role loss in address phase
    clr_mon();
    data_bit(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    sda_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      phase = 2'd1; scl_rise = 1'b1; tick(); scl_rise = 1'b0; tick();
    end
    phase = 2'd0; tick();
    chk("R7 slave loss pulse", n_lost, 1);
    chk("R7 slave loss no role", n_tx + n_rx, 0);
    clear_flag();

    // R8 clear in same cycle as a loss
    clr_mon();
    data_bit(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 collision pulse still", s_lost, 1);
    chk("R8 collision clear wins", s_flag, 0);
    // R8 sticky
    clr_mon();
    data_bit(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (20) tick();
    chk("R8 flag sticky", arb_flag, 1);
    clear_flag();
    chk("R8 flag cleared by strobe", arb_flag, 0);

    // R5 R6 sweep over competing address bytes
    for (int t = 0; t < 256; t++) begin
      for (int o = 0; o < 2; o++) begin
        for (int m = 0; m < 2; m++) begin
          logic [7:0] ours, bus;
          logic [AW-1:0] own;
          ours = (o == 0) ? 8'hFF : (8'(t) ^ 8'h33);
          bus = calc_bus(ours, 8'(t));
          own = (m == 1) ? bus[7:1] : (bus[7:1] ^ 7'h15);
          addr_txn(ours, 8'(t), own);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule